// File: doc/BRIEF.md
# Chained scatter-gather list builder

The block turns a buffer, given as a stream of page-aligned bus addresses plus a start offset into the first page and a total byte length, into a scatter-gather descriptor list. It writes the list into a memory through a simple write port, one 16-byte entry per clock. Entries are grouped into 128-byte blocks of eight. Slot 0 of every block except the last is a link entry that points to the next block. Page pieces that follow on from each other in bus address space are folded into one entry. The list ends with a terminator entry.

Software, or an upstream sequencer, places the job parameters on the inputs and pulses `start_i`. The block first checks the start offset and the size of the list area. If either fails, it reports an error at once. Otherwise it takes one page address per accepted handshake on the page stream. It writes a finished block as soon as a later piece needs room in a new block. At the end it writes the last block in compacted form. `done_o` pulses once the list is complete.

Top module: `sgl_builder`

## Requirements
- R1: Each write places one 16-byte entry at byte address base + 16 × slot, where slot counts from 0 at the list base. The 128-bit data word holds the bus address in bits 127:64, the length in bits 63:32 and the type code in bits 31:0. Bits 127:120 are the byte at the lowest memory address, so every field is big-endian. The type codes are data = 0, link = 1 and terminator = 2.
- R2: In every block except the final one, slot 0 is a link entry. Its address is base + 128 × (block index + 1), its length is 128 and its type is link. Slots 1 to 7 hold data entries.
- R3: The first piece starts at first page + offset and its length is min(length, 4096 − offset). Each later piece starts at its page address and its length is min(remaining length, 4096).
- R4: A piece whose address equals the end address (address + length) of the previous data entry adds its length to that entry and opens no new entry.
- R5: In the final block, the data entries move down one slot, so the first one lands in slot 0 and no link entry remains. The slot after the last data entry holds a terminator with address 0 and length 0. Nothing is written beyond it.
- R6: A block can be full with seven data entries when the last piece merges into its last entry. In that case that block is the final one: its seven entries occupy slots 0 to 6, the terminator sits in slot 7, and no further block is written.
- R7: A start offset greater than 4096 is an error. An offset of exactly 4096 is accepted.
- R8: The list area size must be at least ((pages + pages/7 + 1) × 16) rounded up to a multiple of 4096 bytes. A smaller size is an error, and an exact fit is accepted.
- R9: On an error, `done_o` and `err_o` are both high in the cycle right after the clock edge that samples `start_i`. No entry is written and no page is accepted.
- R10: A job with zero pages writes a single terminator at slot 0.
- R11: After a successful job, `done_o` is high for exactly one cycle, following the terminator write, and `err_o` stays low. The block accepts exactly as many page addresses as the page count. `pg_ready_o` is never high while a write is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a job when the block is idle |
| base_i | input | 64 | Bus address of the list area |
| offs_i | input | OFFS_W | Byte offset into the first page |
| len_i | input | 32 | Total buffer length in bytes |
| npages_i | input | NPG_W | Number of page addresses that follow |
| list_size_i | input | 32 | Size of the list area in bytes |
| pg_valid_i | input | 1 | Page address valid |
| pg_addr_i | input | 64 | Page-aligned bus address |
| pg_ready_o | output | 1 | Page address accepted when both valid and ready are high |
| we_o | output | 1 | Entry write strobe |
| waddr_o | output | 64 | Byte address of the entry being written |
| wdata_o | output | 128 | Entry contents, big-endian |
| done_o | output | 1 | One-cycle job completion pulse |
| err_o | output | 1 | Job rejected, valid while done_o is high |

## Verification
An error verdict is due one cycle after the start edge. The bench therefore samples `done_o` and `err_o` at the first falling edge after that edge and requires a zero-cycle wait. A successful job runs for a number of cycles that depends on the page pattern: one per page, eight per full block and one per slot of the compacted tail. For these jobs the bench drives the page stream at falling edges and counts a page only when valid and ready were both high before the rising edge. It records every write as it happens and compares the memory image with a model computed on its own only once `done_o` has been seen. It then confirms that the pulse lasts one cycle and that the page count and the highest slot written are exact.

// File: rtl/sgl_pkg.sv
package sgl_pkg;
  localparam int ENT_BYTES = 16;
  localparam logic [31:0] FLG_DATA  = 32'd0;
  localparam logic [31:0] FLG_CHAIN = 32'd1;
  localparam logic [31:0] FLG_END   = 32'd2;

  // packed MSB first: byte 0 of the entry is the top byte of addr
  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] len;
    logic [31:0] flags;
  } sgl_ent_t;
endpackage

// File: rtl/sgl_size_chk.sv
module sgl_size_chk
  import sgl_pkg::*;
#(
  parameter int PG_SHIFT = 12,
  parameter int NPG_W    = 16,
  parameter int OFFS_W   = 16,
  parameter int DPB      = 7
) (
  input  logic [NPG_W-1:0]  npages_i,
  input  logic [OFFS_W-1:0] offs_i,
  input  logic [31:0]       list_size_i,
  output logic              bad_o
);
  localparam int CW = NPG_W + PG_SHIFT + 8;
  localparam logic [CW-1:0] PG = CW'(1) << PG_SHIFT;

  logic [CW-1:0] ents, need, rnd;

  always_comb begin
    ents  = CW'(npages_i) + CW'(npages_i) / CW'(DPB) + CW'(1);
    need  = ents * CW'(ENT_BYTES);
    rnd   = ((need + PG - CW'(1)) >> PG_SHIFT) << PG_SHIFT;
    bad_o = (CW'(offs_i) > PG) || (CW'(list_size_i) < rnd);
  end
endmodule

// File: rtl/sgl_piece.sv
module sgl_piece #(
  parameter int PG_SHIFT = 12,
  parameter int OFFS_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [31:0]       len_i,
  input  logic [OFFS_W-1:0] offs_i,
  input  logic              step_i,
  input  logic [63:0]       pg_addr_i,
  output logic [63:0]       addr_o,
  output logic [31:0]       len_o
);
  localparam int MW = PG_SHIFT + 1;
  localparam logic [MW-1:0] PG = MW'(1) << PG_SHIFT;

  logic [31:0]   rem_q;
  logic [MW-1:0] moff_q;
  logic [MW-1:0] room;

  always_comb begin
    room   = PG - moff_q;
    len_o  = (rem_q < 32'(room)) ? rem_q : 32'(room);
    addr_o = pg_addr_i + 64'(moff_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      moff_q <= '0;
    end else if (load_i) begin
      rem_q  <= len_i;
      moff_q <= offs_i[MW-1:0];
    end else if (step_i) begin
      rem_q  <= rem_q - len_o;
      moff_q <= '0;
    end
  end
endmodule

// File: rtl/sgl_blkbuf.sv
module sgl_blkbuf
  import sgl_pkg::*;
#(
  parameter int DPB = 7,
  parameter int CW  = $clog2(DPB + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          nblk_i,
  input  logic          app_i,
  input  logic          mrg_i,
  input  sgl_ent_t      ent_i,
  input  logic [31:0]   mrg_len_i,
  input  logic [CW-1:0] rd_idx_i,
  output sgl_ent_t      rd_o,
  output logic [CW-1:0] cnt_o,
  output logic          have_o,
  output logic [63:0]   end_o
);
  logic [CW-1:0] cnt_q;
  logic          have_q;
  logic [63:0]   end_q;
  sgl_ent_t      slot_w [DPB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      have_q <= 1'b0;
      end_q  <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      have_q <= 1'b0;
    end else if (nblk_i) begin
      cnt_q  <= CW'(1);
      have_q <= 1'b1;
      end_q  <= ent_i.addr + 64'(ent_i.len);
    end else if (app_i) begin
      cnt_q  <= cnt_q + CW'(1);
      have_q <= 1'b1;
      end_q  <= ent_i.addr + 64'(ent_i.len);
    end else if (mrg_i) begin
      end_q  <= end_q + 64'(mrg_len_i);
    end
  end

  for (genvar k = 0; k < DPB; k++) begin : g_slot
    sgl_ent_t e_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        e_q <= '0;
      end else if (nblk_i) begin
        if (k == 0) e_q <= ent_i;
      end else if (app_i && cnt_q == CW'(k)) begin
        e_q <= ent_i;
      end else if (mrg_i && cnt_q == CW'(k + 1)) begin
        e_q.len <= e_q.len + mrg_len_i;
      end
    end
    assign slot_w[k] = e_q;
  end

  always_comb begin
    rd_o = '0;
    for (int k = 0; k < DPB; k++) begin
      if (rd_idx_i == CW'(k)) rd_o = slot_w[k];
    end
  end

  assign cnt_o  = cnt_q;
  assign have_o = have_q;
  assign end_o  = end_q;
endmodule

// File: rtl/sgl_builder.sv
module sgl_builder
  import sgl_pkg::*;
#(
  parameter int PG_SHIFT = 12,
  parameter int ENT_BLK  = 8,
  parameter int NPG_W    = 16,
  parameter int OFFS_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [63:0]       base_i,
  input  logic [OFFS_W-1:0] offs_i,
  input  logic [31:0]       len_i,
  input  logic [NPG_W-1:0]  npages_i,
  input  logic [31:0]       list_size_i,
  input  logic              pg_valid_i,
  input  logic [63:0]       pg_addr_i,
  output logic              pg_ready_o,
  output logic              we_o,
  output logic [63:0]       waddr_o,
  output logic [127:0]      wdata_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int DPB    = ENT_BLK - 1;
  localparam int CW     = $clog2(ENT_BLK);
  localparam int BLK_SH = $clog2(ENT_BLK * ENT_BYTES);
  localparam int ENT_SH = $clog2(ENT_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_FLUSH, S_FIN, S_DONE} st_t;

  st_t              st_q;
  logic [63:0]      base_q;
  logic [NPG_W-1:0] npl_q;
  logic [NPG_W-1:0] blk_q;
  logic [CW-1:0]    wi_q;
  sgl_ent_t         pend_q;
  logic             err_q;

  logic          bad, go, acc, is_mrg, full, nblk;
  logic [63:0]   pc_addr;
  logic [31:0]   pc_len;
  sgl_ent_t      pe, buf_in, rd, wr_ent;
  logic [CW-1:0] rd_idx, cnt;
  logic          have;
  logic [63:0]   last_end;

  sgl_size_chk #(
    .PG_SHIFT(PG_SHIFT), .NPG_W(NPG_W), .OFFS_W(OFFS_W), .DPB(DPB)
  ) i_size_chk (
    .npages_i(npages_i), .offs_i(offs_i), .list_size_i(list_size_i), .bad_o(bad)
  );

  sgl_piece #(.PG_SHIFT(PG_SHIFT), .OFFS_W(OFFS_W)) i_piece (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(go), .len_i(len_i), .offs_i(offs_i),
    .step_i(acc), .pg_addr_i(pg_addr_i), .addr_o(pc_addr), .len_o(pc_len)
  );

  always_comb begin
    go     = (st_q == S_IDLE) && start_i;
    acc    = (st_q == S_RUN) && pg_valid_i;
    pe     = '{addr: pc_addr, len: pc_len, flags: FLG_DATA};
    is_mrg = acc && have && (pc_addr == last_end);
    full   = (cnt == CW'(DPB));
    nblk   = (st_q == S_FLUSH) && (wi_q == CW'(ENT_BLK - 1));
    buf_in = nblk ? pend_q : pe;
    rd_idx = (st_q == S_FLUSH) ? wi_q - CW'(1) : wi_q;
  end

  sgl_blkbuf #(.DPB(DPB), .CW(CW)) i_blkbuf (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(go), .nblk_i(nblk),
    .app_i(acc && !is_mrg && !full), .mrg_i(is_mrg), .ent_i(buf_in),
    .mrg_len_i(pc_len), .rd_idx_i(rd_idx), .rd_o(rd), .cnt_o(cnt),
    .have_o(have), .end_o(last_end)
  );

  // write side: link entry on flush slot 0, terminator after the last data slot
  always_comb begin
    wr_ent = '0;
    if (st_q == S_FLUSH) begin
      if (wi_q == '0)
        wr_ent = '{addr: base_q + ((64'(blk_q) + 64'd1) << BLK_SH),
                   len: 32'(ENT_BLK * ENT_BYTES), flags: FLG_CHAIN};
      else
        wr_ent = rd;
    end else if (st_q == S_FIN) begin
      if (wi_q == cnt) wr_ent = '{addr: '0, len: '0, flags: FLG_END};
      else             wr_ent = rd;
    end
  end

  assign we_o       = (st_q == S_FLUSH) || (st_q == S_FIN);
  assign waddr_o    = base_q + (64'(blk_q) << BLK_SH) + (64'(wi_q) << ENT_SH);
  assign wdata_o    = wr_ent;
  assign pg_ready_o = (st_q == S_RUN);
  assign done_o     = (st_q == S_DONE);
  assign err_o      = (st_q == S_DONE) && err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      base_q <= '0;
      npl_q  <= '0;
      blk_q  <= '0;
      wi_q   <= '0;
      pend_q <= '0;
      err_q  <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          base_q <= base_i;
          npl_q  <= npages_i;
          blk_q  <= '0;
          wi_q   <= '0;
          err_q  <= bad;
          if (bad)                  st_q <= S_DONE;
          else if (npages_i == '0)  st_q <= S_FIN;
          else                      st_q <= S_RUN;
        end
        S_RUN: if (acc) begin
          npl_q <= npl_q - NPG_W'(1);
          if (!is_mrg && full) begin
            pend_q <= pe;
            wi_q   <= '0;
            st_q   <= S_FLUSH;
          end else if (npl_q == NPG_W'(1)) begin
            wi_q <= '0;
            st_q <= S_FIN;
          end
        end
        S_FLUSH: begin
          wi_q <= wi_q + CW'(1);
          if (nblk) begin
            blk_q <= blk_q + NPG_W'(1);
            wi_q  <= '0;
            st_q  <= (npl_q == '0) ? S_FIN : S_RUN;
          end
        end
        S_FIN: begin
          if (wi_q == cnt) st_q <= S_DONE;
          else             wi_q <= wi_q + CW'(1);
        end
        S_DONE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgl_builder_chk.sv
module sgl_builder_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         we_o,
  input logic         done_o,
  input logic         err_o,
  input logic         pg_ready_o,
  input logic [127:0] wdata_o
);
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  // R11
  quiet_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!we_o && !pg_ready_o));

  // R11
  ready_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_ready_o |-> !we_o);

  // R1
  type_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (wdata_o[31:0] <= 32'd2));

  // R2
  link_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && wdata_o[31:0] == 32'd1) |-> (wdata_o[63:32] == 32'd128));

  // R5
  term_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && wdata_o[31:0] == 32'd2) |-> (wdata_o[127:32] == '0));
endmodule

bind sgl_builder sgl_builder_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_o(we_o), .done_o(done_o),
  .err_o(err_o), .pg_ready_o(pg_ready_o), .wdata_o(wdata_o)
);

// File: tb/test_sgl_builder.sv
`timescale 1ns/1ps
module test_sgl_builder;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [63:0]  base_i = '0;
  logic [15:0]  offs_i = '0;
  logic [31:0]  len_i = '0;
  logic [15:0]  npages_i = '0;
  logic [31:0]  list_size_i = '0;
  logic         pg_valid_i = 1'b0;
  logic [63:0]  pg_addr_i = '0;
  logic         pg_ready_o, we_o, done_o, err_o;
  logic [63:0]  waddr_o;
  logic [127:0] wdata_o;

  sgl_builder i_sgl_builder (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  logic [63:0]  pg [0:31];
  logic [127:0] mem [0:63];
  logic [127:0] exp_m [0:63];
  int used, maxs, wcnt, oob, pidx, lat;
  bit got_done, got_err;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  always @(posedge clk_i) begin
    if (we_o) begin
      automatic logic [63:0] sl = (waddr_o - base_i) >> 4;
      wcnt++;
      if (sl < 64) begin
        mem[sl[5:0]] = wdata_o;
        if (int'(sl) > maxs) maxs = int'(sl);
      end else oob++;
    end
  end

  task automatic run_job();
    int cyc = 0;
    bit acc;
    pidx = 0; wcnt = 0; maxs = -1; oob = 0;
    for (int i = 0; i < 64; i++) mem[i] = {4{32'hDEADBEEF}};
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    while (!done_o && cyc < 5000) begin
      pg_valid_i = (pidx < int'(npages_i));
      pg_addr_i  = pg_valid_i ? pg[pidx] : '0;
      acc = pg_valid_i && pg_ready_o;
      @(posedge clk_i);
      if (acc) pidx++;
      @(negedge clk_i);
      cyc++;
    end
    pg_valid_i = 1'b0;
    got_done = done_o; got_err = err_o; lat = cyc;
    @(negedge clk_i);
    chk(!done_o, "R11", "done pulse width", 128'(done_o), 128'd0);
  endtask

  // model built from the requirements: eager link entries, tail compaction
  task automatic build_ref();
    int s = 0, j = 0, last = 0, p = 0, n;
    bit fin = 0, have = 0;
    logic [63:0] a, pend;
    logic [31:0] rem, plen, room, moff;
    for (int i = 0; i < 64; i++) exp_m[i] = '0;
    if (npages_i == 0) begin
      exp_m[0] = {64'd0, 32'd0, 32'd2}; used = 1; return;
    end
    rem = len_i; moff = 32'(offs_i); pend = '0;
    while (!fin) begin
      exp_m[s] = {base_i + 64'(128 * (s / 8 + 1)), 32'd128, 32'd1};
      j = 1;
      while (j < 8 && !fin) begin
        room = 32'd4096 - moff;
        plen = (rem < room) ? rem : room;
        a = pg[p] + 64'(moff);
        rem -= plen; moff = 0;
        if (have && a == pend) exp_m[last][63:32] += plen;
        else begin exp_m[s+j] = {a, plen, 32'd0}; last = s + j; j++; end
        pend = a + 64'(plen); have = 1; p++;
        if (p == int'(npages_i)) fin = 1;
      end
      if (!fin) s += 8;
    end
    n = j - 1;
    if (j == 1) begin s -= 8; n = 7; end
    for (int i = 0; i < n; i++) exp_m[s+i] = exp_m[s+i+1];
    exp_m[s+n] = {64'd0, 32'd0, 32'd2};
    used = s + n + 1;
  endtask

  task automatic run_ok(input string req);
    int bad = -1;
    run_job();
    build_ref();
    chk(got_done, "R11", "done seen", 128'(got_done), 128'd1);
    chk(!got_err, req, "no error on valid job", 128'(got_err), 128'd0);
    chk(pidx == int'(npages_i), "R11", "pages accepted", 128'(pidx), 128'(npages_i));
    chk(maxs == used - 1 && oob == 0, "R5", "last slot written", 128'(maxs), 128'(used - 1));
    for (int i = 0; i < used; i++) if (bad < 0 && mem[i] !== exp_m[i]) bad = i;
    if (bad >= 0) chk(0, req, $sformatf("list slot %0d", bad), mem[bad], exp_m[bad]);
    else          chk(1, req, "list image", '0, '0);
  endtask

  task automatic run_err(input string req);
    run_job();
    chk(got_done && got_err && lat == 0, "R9", {req, " error verdict timing"},
        128'({got_done, got_err, 8'(lat)}), 128'({2'b11, 8'd0}));
    chk(wcnt == 0 && pidx == 0, "R9", "no writes or pages on error",
        128'({16'(wcnt), 16'(pidx)}), 128'd0);
  endtask

  task automatic setup(input int np, input logic [15:0] offs, input logic [31:0] len,
                       input logic [31:0] lsz);
    npages_i = 16'(np); offs_i = offs; len_i = len; list_size_i = lsz;
    base_i = 64'h0000_0080_0001_0000;
  endtask

  task automatic sparse(input int np);
    for (int k = 0; k < 32; k++) pg[k] = 64'h0000_0012_0000_0000 + 64'(k) * 64'h3_0000;
  endtask

  task automatic t_reset();
    chk(!done_o && !err_o && !we_o && !pg_ready_o, "R11", "reset outputs",
        128'({done_o, err_o, we_o, pg_ready_o}), 128'd0);
  endtask

  // R1 R3 R5: single page with offset, explicit entry image
  task automatic t_single();
    sparse(1); setup(1, 16'h100, 32'h200, 32'd4096);
    run_ok("R3");
    chk(mem[0] == {pg[0] + 64'h100, 32'h200, 32'd0}, "R1", "data entry layout",
        mem[0], {pg[0] + 64'h100, 32'h200, 32'd0});
    chk(mem[1] == {64'd0, 32'd0, 32'd2}, "R5", "terminator", mem[1], {96'd0, 32'd2});
  endtask

  task automatic t_multi();
    sparse(3); setup(3, 16'h200, 32'h2100, 32'd4096);
    run_ok("R3");
  endtask

  task automatic t_contig();
    for (int k = 0; k < 4; k++) pg[k] = 64'h0000_0034_0000_0000 + 64'(k) * 64'h1000;
    setup(4, 16'h10, 32'h3000, 32'd4096);
    run_ok("R4");
    chk(mem[0] == {pg[0] + 64'h10, 32'h3000, 32'd0}, "R4", "merged entry",
        mem[0], {pg[0] + 64'h10, 32'h3000, 32'd0});
  endtask

  // R2 plus exact-fit list area for R8
  task automatic t_chain9();
    sparse(9); setup(9, 16'h0, 32'd9 * 4096, 32'd4096);
    run_ok("R2");
    chk(mem[0] == {base_i + 64'd128, 32'd128, 32'd1}, "R2", "link entry",
        mem[0], {base_i + 64'd128, 32'd128, 32'd1});
    chk(!got_err, "R8", "exact list size accepted", 128'(got_err), 128'd0);
  endtask

  task automatic t_full_merge();
    sparse(7); pg[7] = pg[6] + 64'h1000;
    setup(8, 16'h0, 32'd8 * 4096, 32'd4096);
    run_ok("R6");
    chk(used == 8 && mem[7] == {96'd0, 32'd2}, "R6", "terminator in slot 7",
        mem[7], {96'd0, 32'd2});
    chk(mem[6][63:32] == 32'h2000, "R6", "merged length", 128'(mem[6][63:32]), 128'h2000);
  endtask

  task automatic t_chain15();
    sparse(15); setup(15, 16'h80, 32'd15 * 4096 - 32'h180, 32'd4096);
    run_ok("R2");
    chk(mem[8] == {base_i + 64'd256, 32'd128, 32'd1}, "R2", "second link",
        mem[8], {base_i + 64'd256, 32'd128, 32'd1});
  endtask

  task automatic t_offs();
    sparse(1); setup(1, 16'd4097, 32'h10, 32'd4096);
    run_err("R7");
    setup(1, 16'd4096, 32'h10, 32'd4096);
    run_ok("R7");
    chk(mem[0] == {pg[0] + 64'h1000, 32'd0, 32'd0}, "R7", "offset at page size",
        mem[0], {pg[0] + 64'h1000, 32'd0, 32'd0});
  endtask

  task automatic t_size();
    sparse(7); setup(7, 16'h0, 32'd7 * 4096, 32'd4095);
    run_err("R8");
    setup(300, 16'h0, 32'd4096, 32'd8191);
    run_err("R8");
  endtask

  task automatic t_zero();
    setup(0, 16'h0, 32'd0, 32'd4096);
    run_ok("R10");
    chk(mem[0] == {96'd0, 32'd2} && wcnt == 1, "R10", "lone terminator",
        mem[0], {96'd0, 32'd2});
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_single();
    t_multi();
    t_contig();
    t_chain9();
    t_full_merge();
    t_chain15();
    t_offs();
    t_size();
    t_zero();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule